// File: doc/BRIEF.md
# Prescaled 6/9-bit PWM Generator

This block produces one pulse-width-modulated output from a chain of three counters. A source tick is chosen from three free-running tick inputs, or none. A pre-divider counts that tick by 2, 3, 5 or 6. A power-of-two stage then divides by 2^m. The stage output advances a duty counter that is 6 or 9 bits wide. The output is high while the duty counter is below the captured duty value.

The duty value comes from one of two places: a register input, or a value fed by an external ramp sequencer. A select bit picks between them. The captured value is replaced only when a period wraps, so a change never cuts a pulse short. While the PWM enable is low, all counters are held at zero and the capture register follows the selected source. Raising the enable therefore starts a clean period with the current duty. The output enable only masks the pin.

Top module: `pwm_prescaled_gen`

## Requirements
- R1: After reset `pwm_out` is low and every counter is zero.
- R2: With the selected source ticking every clock, one period lasts d × 2^m × 2^N clocks, and the output is high for duty × d × 2^m of those clocks, starting with the first clock after enable.
- R3: `prediv_sel` codes 0, 1, 2, 3 select pre-divide values 2, 3, 5, 6.
- R4: `exp_m` (0 to 7) multiplies the step length by 2^m.
- R5: `size9`=1 selects a 9-bit duty counter (N=9). `size9`=0 selects 6 bits (N=6), and only duty bits 5..0 are used.
- R6: `clk_sel` selects the source tick: 0 none, 1 `tick_lo`, 2 `tick_mid`, 3 `tick_hi`. With no ticks arriving the duty counter stays at zero.
- R7: `use_reg_duty`=1 takes the duty from `reg_duty`, and 0 takes it from `ramp_duty`.
- R8: `pwm_out` can be high only while both `pwm_en` and `out_en` are high. While `pwm_en` is low the counters are held at zero.
- R9: While running, a new duty value takes effect only at the next period wrap.
- R10: A duty value of zero gives a constantly low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_lo | input | 1 | Slow source tick, one clock wide |
| tick_mid | input | 1 | Medium source tick, one clock wide |
| tick_hi | input | 1 | Fast source tick, one clock wide |
| clk_sel | input | 2 | Source select: 0 none, 1 lo, 2 mid, 3 hi |
| prediv_sel | input | 2 | Pre-divide select: 2, 3, 5, 6 |
| exp_m | input | 3 | Power-of-two exponent |
| size9 | input | 1 | 1 = 9-bit counter, 0 = 6-bit counter |
| reg_duty | input | 9 | Register duty value |
| ramp_duty | input | 9 | Duty value from the ramp sequencer |
| use_reg_duty | input | 1 | 1 = register duty, 0 = ramp duty |
| pwm_en | input | 1 | Runs the counters |
| out_en | input | 1 | Lets the waveform reach the pin |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench counts high clocks over exactly one computed period for each pre-divide code, for several exponents and for both sizes. An off-by-one in a divider limit or an exponent mask therefore shows up as a wrong count. A 9-bit duty value is applied in 6-bit mode: a design that failed to mask the value would hold the output high for the whole period. A duty change in the middle of a period must leave the current period's high count intact. A design that updated the duty at once would produce a longer first pulse. Starving the counter of ticks through codes 0 and 2 exposes a design that counts on the wrong tick, because the output would toggle instead of staying high.

// File: rtl/pwm_prescaled_gen.sv
module pwm_prescaled_gen #(
  parameter int EXP_W   = 3,
  parameter int DUTY_W  = 9,
  parameter int SMALL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_lo,
  input  logic              tick_mid,
  input  logic              tick_hi,
  input  logic [1:0]        clk_sel,
  input  logic [1:0]        prediv_sel,
  input  logic [EXP_W-1:0]  exp_m,
  input  logic              size9,
  input  logic [DUTY_W-1:0] reg_duty,
  input  logic [DUTY_W-1:0] ramp_duty,
  input  logic              use_reg_duty,
  input  logic              pwm_en,
  input  logic              out_en,
  output logic              pwm_out
);
  localparam int EXP_CNT_W = (1 << EXP_W) - 1;
  localparam logic [DUTY_W-1:0] SMALL_TOP = DUTY_W'((1 << SMALL_W) - 1);

  logic                  src_tick;
  logic [2:0]            pre_cnt, pre_lim;
  logic [EXP_CNT_W-1:0]  exp_cnt, exp_lim;
  logic [DUTY_W-1:0]     cnt, top, duty_lat, duty_new;
  logic                  pre_wrap, exp_wrap, period_end;

  always_comb begin
    case (clk_sel)
      2'd1:    src_tick = tick_lo;
      2'd2:    src_tick = tick_mid;
      2'd3:    src_tick = tick_hi;
      default: src_tick = 1'b0;
    endcase
  end

  always_comb begin
    case (prediv_sel)
      2'd0:    pre_lim = 3'd1;
      2'd1:    pre_lim = 3'd2;
      2'd2:    pre_lim = 3'd4;
      default: pre_lim = 3'd5;
    endcase
  end

  assign exp_lim    = ~({EXP_CNT_W{1'b1}} << exp_m);
  assign top        = size9 ? {DUTY_W{1'b1}} : SMALL_TOP;
  assign duty_new   = (use_reg_duty ? reg_duty : ramp_duty) & top;
  assign pre_wrap   = src_tick && (pre_cnt >= pre_lim);
  assign exp_wrap   = pre_wrap && (exp_cnt >= exp_lim);
  assign period_end = exp_wrap && (cnt >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      exp_cnt  <= '0;
      cnt      <= '0;
      duty_lat <= '0;
    end else if (!pwm_en) begin
      pre_cnt  <= '0;
      exp_cnt  <= '0;
      cnt      <= '0;
      duty_lat <= duty_new;
    end else begin
      if (src_tick)   pre_cnt  <= pre_wrap ? '0 : pre_cnt + 3'd1;
      if (pre_wrap)   exp_cnt  <= exp_wrap ? '0 : exp_cnt + 1'b1;
      if (exp_wrap)   cnt      <= period_end ? '0 : cnt + 1'b1;
      if (period_end) duty_lat <= duty_new;
    end
  end

  assign pwm_out = pwm_en && out_en && (cnt < duty_lat);

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;

  // R9
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && pwm_en && $past(pwm_en) && !$past(period_end)) |-> $stable(duty_lat));

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> (cnt == '0 && pre_cnt == '0 && exp_cnt == '0));

  // R6
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && clk_sel == 2'd0 && $past(clk_sel) == 2'd0 && pwm_en && $past(pwm_en))
    |-> $stable(cnt));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && pwm_en && $past(pwm_en))
    |-> (cnt == $past(cnt) || cnt == DUTY_W'($past(cnt) + 1'b1) || cnt == '0));

  // R10
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_lat == '0) |-> !pwm_out);
endmodule

// File: tb/pwm_prescaled_gen_bench.sv
module pwm_prescaled_gen_bench;
  logic       clk = 0, rst_n = 0;
  logic       tick_lo = 0, tick_mid = 0, tick_hi = 1;
  logic [1:0] clk_sel = 3, prediv_sel = 0;
  logic [2:0] exp_m = 0;
  logic       size9 = 0, use_reg_duty = 1, pwm_en = 0, out_en = 0;
  logic [8:0] reg_duty = 0, ramp_duty = 0;
  logic       pwm_out;
  int checks = 0, fails = 0;
  bit done = 0;

  pwm_prescaled_gen u_pwm_prescaled_gen (
    .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_mid(tick_mid), .tick_hi(tick_hi),
    .clk_sel(clk_sel), .prediv_sel(prediv_sel), .exp_m(exp_m), .size9(size9),
    .reg_duty(reg_duty), .ramp_duty(ramp_duty), .use_reg_duty(use_reg_duty),
    .pwm_en(pwm_en), .out_en(out_en), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  int lo_div = 0;
  always @(negedge clk) begin
    lo_div  <= (lo_div == 3) ? 0 : lo_div + 1;
    tick_lo <= (lo_div == 3);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] sel, input logic [1:0] pd, input logic [2:0] m,
                       input logic s9, input logic [8:0] rd, input logic [8:0] rp,
                       input logic ur, input logic oe);
    @(negedge clk);
    pwm_en = 0; clk_sel = sel; prediv_sel = pd; exp_m = m; size9 = s9;
    reg_duty = rd; ramp_duty = rp; use_reg_duty = ur;
    @(negedge clk);
    pwm_en = 1; out_en = oe;
  endtask

  task automatic measure(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    #1;
    check("R1 output after reset", pwm_out, 0);
  endtask

  task automatic t_prediv;
    int h;
    // R3 R2: codes 0..3 -> 2,3,5,6, size 6, m 0, duty 20
    start(3, 0, 0, 0, 20, 0, 1, 1); measure(2*64, h); check("R3 div2", h, 20*2);
    start(3, 1, 0, 0, 20, 0, 1, 1); measure(3*64, h); check("R3 div3", h, 20*3);
    start(3, 2, 0, 0, 20, 0, 1, 1); measure(5*64, h); check("R3 div5", h, 20*5);
    start(3, 3, 0, 0, 20, 0, 1, 1); measure(6*64, h); check("R3 div6", h, 20*6);
  endtask

  task automatic t_exp;
    int h;
    // R4
    start(3, 1, 3, 0, 20, 0, 1, 1); measure(3*8*64, h); check("R4 m3 div3", h, 20*3*8);
    start(3, 3, 1, 0, 63, 0, 1, 1); measure(6*2*64, h); check("R4 m1 div6", h, 63*6*2);
    start(3, 0, 7, 0, 1, 0, 1, 1); measure(2*128*64, h); check("R4 m7 div2", h, 2*128);
  endtask

  task automatic t_size;
    int h;
    // R5: 9-bit counter
    start(3, 2, 0, 1, 300, 0, 1, 1); measure(5*512, h); check("R5 9-bit", h, 300*5);
    // R5: 6-bit uses only bits 5..0 (453 -> 5)
    start(3, 0, 0, 0, 453, 0, 1, 1); measure(2*64, h); check("R5 6-bit mask", h, 5*2);
  endtask

  task automatic t_source;
    int h;
    // R6: tick_lo every 4 clocks
    start(1, 0, 0, 0, 16, 0, 1, 1); measure(4*2*64, h); check("R6 slow tick", h, 16*2*4);
    // R6: code 0 and silent mid tick freeze counter -> always high
    start(0, 0, 0, 0, 5, 0, 1, 1); measure(300, h); check("R6 no clock", h, 300);
    start(2, 0, 0, 0, 5, 0, 1, 1); measure(300, h); check("R6 mid silent", h, 300);
  endtask

  task automatic t_duty_src;
    int h;
    // R7: ramp value used when select is 0
    start(3, 0, 0, 0, 10, 40, 0, 1); measure(2*64, h); check("R7 ramp source", h, 40*2);
    start(3, 0, 0, 0, 10, 40, 1, 1); measure(2*64, h); check("R7 reg source", h, 10*2);
  endtask

  task automatic t_enable;
    int h;
    // R8: output enable low masks the pin
    start(3, 0, 0, 0, 30, 0, 1, 0); measure(128, h); check("R8 out_en low", h, 0);
    // R8: pwm_en low keeps output low
    @(negedge clk); pwm_en = 0; out_en = 1;
    measure(128, h); check("R8 pwm_en low", h, 0);
  endtask

  task automatic t_boundary;
    int h1, h2;
    // R9: change at sample 10, effective from sample 128
    start(3, 0, 0, 0, 16, 0, 1, 1);
    h1 = 0; h2 = 0;
    for (int i = 0; i < 256; i++) begin
      #1;
      if (i == 10) reg_duty = 48;
      if (pwm_out) begin
        if (i < 128) h1++; else h2++;
      end
      @(negedge clk);
    end
    check("R9 old period kept", h1, 32);
    check("R9 new period", h2, 96);
  endtask

  task automatic t_zero;
    int h;
    // R10
    start(3, 0, 0, 1, 0, 0, 1, 1); measure(1024, h); check("R10 duty zero", h, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_prediv();
    t_exp();
    t_size();
    t_source();
    t_duty_src();
    t_enable();
    t_boundary();
    t_zero();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule